// File: doc/BRIEF.md
# PAM-3 Transmitter Compliance Pattern Source

This block drives a stream of three-level line symbols used to qualify the output stage of a single-pair Ethernet transmitter. It is meant to sit just ahead of the line driver. The driver and its shaping stay outside the block. A two-bit mode input selects one of these outputs:
- a steady zero level;
- a one-symbol alternation between the two outer levels;
- a square wave made of runs of RUN_LEN equal symbols, with RUN_LEN at 10 by default.

The block does not assume any fixed ratio between the fabric clock and the line symbol rate. The nominal line rate is 7.5 Msymbol/s. It can be derived from 10 MHz as three symbols in every four reference cycles. The pattern therefore moves forward only on cycles where the symbol enable is high. On every other cycle the output holds its value. A change of mode, or a drop of the run control, returns the pattern to its starting phase. The next emitted symbol after such a restart is always the positive level.

Top module: `pam3_pattern_gen`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, `sym_out` is 2'b00 and `sym_valid` is 0.
- R2: `sym_out` only ever carries one of three codes: 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. The code 2'b10 never appears.
- R3: `sym_valid` equals the value `run` had on the previous clock edge.
- R4: In alternation mode (`mode` = 2'b01), each enabled cycle emits the next symbol of +1, -1, +1, -1 and so on, starting from +1.
- R5: In run mode (`mode` = 2'b10), each enabled cycle emits the next symbol of a sequence of RUN_LEN +1 symbols followed by RUN_LEN -1 symbols, repeated, starting from +1.
- R6: With `run` high and `mode` at 2'b00 (quiet) or 2'b11 (reserved, also treated as quiet), the output on the next cycle is 0.
- R7: On a cycle where a pattern mode is steady, `run` is high and `sym_en` is low, `sym_out` keeps its previous value.
- R8: A cycle whose `mode` differs from the mode of the previous cycle drives the output to 0. The following pattern then starts with +1 on its first enabled cycle.
- R9: While `run` is low, the output is 0. When `run` returns high, the pattern starts again from +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_en | input | 1 | Symbol-rate qualifier; the pattern advances only when this is high |
| run | input | 1 | Enables generation; low forces a zero output and a phase restart |
| mode | input | 2 | 00 quiet, 01 alternation, 10 runs of RUN_LEN, 11 quiet |
| sym_out | output | 2 | Registered signed symbol: 01 = +1, 00 = 0, 11 = -1 |
| sym_valid | output | 1 | Registered copy of `run` |

## Verification
The bench drives the symbol enable in two ways: continuously, and with irregular gaps such as a three-of-four cadence. This exposes any design that counts clock cycles instead of enabled cycles. Such a design would stretch or shorten runs, or flip polarity while stalled.

The run boundary at RUN_LEN is crossed several times, once with stalls on each side. This catches an off-by-one run length. The bench also switches mode in the middle of a run, and on a cycle where the enable is high. A design that kept its old phase across the switch would start the new pattern with -1 or part-way through a run.

Run is dropped mid-pattern and then restored, and the reserved mode is exercised. These steps check that the restart and the quiet output both apply.

// File: rtl/pam3_pkg.sv
package pam3_pkg;
  typedef logic [1:0] sym_t;

  localparam sym_t SYM_POS  = 2'b01;
  localparam sym_t SYM_ZERO = 2'b00;
  localparam sym_t SYM_NEG  = 2'b11;

  typedef enum logic [1:0] {
    MODE_QUIET = 2'b00,
    MODE_ALT   = 2'b01,
    MODE_RUNS  = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;
endpackage

// File: rtl/pam3_restart_ctrl.sv
module pam3_restart_ctrl
  import pam3_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  output logic       restart,
  output logic       pattern_go,
  output logic       runs_mode
);
  mode_e mode_cur;
  mode_e mode_q;

  assign mode_cur = mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_QUIET;
    else     mode_q <= mode_cur;
  end

  assign restart    = !run || (mode_cur != mode_q);
  assign runs_mode  = (mode_cur == MODE_RUNS);
  assign pattern_go = !restart && ((mode_cur == MODE_ALT) || (mode_cur == MODE_RUNS));

  // A steady pattern mode on this cycle means the same mode was seen on the last one.
  assert_go_needs_steady_mode_R8: assert property (@(posedge clk) disable iff (rst)
    pattern_go |-> (mode == $past(mode)));
endmodule

// File: rtl/pam3_phase_seq.sv
module pam3_phase_seq #(
  parameter int RUN_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic adv,
  input  logic runs_mode,
  output logic level_pos
);
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      level_pos <= 1'b1;
      run_cnt   <= '0;
    end else if (adv) begin
      if (!runs_mode) begin
        level_pos <= ~level_pos;
      end else if (run_cnt == LAST) begin
        run_cnt   <= '0;
        level_pos <= ~level_pos;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= LAST);

  assert_alt_flips_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && !runs_mode && !restart) |=> (level_pos != $past(level_pos)));
endmodule

// File: rtl/pam3_pattern_gen.sv
module pam3_pattern_gen
  import pam3_pkg::*;
#(
  parameter int RUN_LEN = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_en,
  input  logic       run,
  input  logic [1:0] mode,
  output logic [1:0] sym_out,
  output logic       sym_valid
);
  logic restart;
  logic pattern_go;
  logic runs_mode;
  logic adv;
  logic level_pos;
  sym_t sym_next;

  pam3_restart_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .mode       (mode),
    .restart    (restart),
    .pattern_go (pattern_go),
    .runs_mode  (runs_mode)
  );

  assign adv = sym_en && pattern_go;

  pam3_phase_seq #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .adv       (adv),
    .runs_mode (runs_mode),
    .level_pos (level_pos)
  );

  always_comb begin
    if (adv)             sym_next = level_pos ? SYM_POS : SYM_NEG;
    else if (pattern_go) sym_next = sym_out;
    else                 sym_next = SYM_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out   <= SYM_ZERO;
      sym_valid <= 1'b0;
    end else begin
      sym_out   <= sym_next;
      sym_valid <= run;
    end
  end

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    sym_out != 2'b10);

  assert_valid_follows_run_R3: assert property (@(posedge clk) disable iff (rst)
    run |=> sym_valid);

  assert_valid_drops_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sym_valid);

  assert_quiet_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (run && (mode == MODE_QUIET || mode == MODE_RSVD)) |=> (sym_out == SYM_ZERO));

  assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (rst)
    (pattern_go && !sym_en) |=> $stable(sym_out));

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (sym_out == SYM_ZERO));
endmodule

// File: tb/pam3_pattern_gen_tb.sv
module pam3_pattern_gen_tb;
  localparam int RUN_LEN = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       sym_en;
  logic       run;
  logic [1:0] mode;
  logic [1:0] sym_out;
  logic       sym_valid;

  int n_chk  = 0;
  int n_fail = 0;
  int k      = 0;
  logic [1:0] prev_mode = 2'b00;
  logic [1:0] exp_sym   = 2'b00;
  logic       exp_valid = 1'b0;

  always #10 clk = ~clk;

  pam3_pattern_gen #(.RUN_LEN(RUN_LEN)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .sym_en    (sym_en),
    .run       (run),
    .mode      (mode),
    .sym_out   (sym_out),
    .sym_valid (sym_valid)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One clock of stimulus; expected output is derived from the requirement text.
  task automatic step(input logic r, input logic [1:0] m, input logic e);
    string req;
    @(negedge clk);
    run = r; mode = m; sym_en = e;
    if (!r) begin
      exp_sym = 2'b00; k = 0; req = "R9";
    end else if (m != prev_mode) begin
      exp_sym = 2'b00; k = 0; req = "R8";
    end else if (m == 2'b01 || m == 2'b10) begin
      if (e) begin
        if (m == 2'b01) begin
          exp_sym = (k % 2 == 0) ? 2'b01 : 2'b11; req = "R4";
        end else begin
          exp_sym = (((k / RUN_LEN) % 2) == 0) ? 2'b01 : 2'b11; req = "R5";
        end
        k++;
      end else begin
        req = "R7";
      end
    end else begin
      exp_sym = 2'b00; req = "R6";
    end
    exp_valid = r;
    prev_mode = m;
    @(posedge clk); #1;
    check(req,  sym_out, exp_sym);
    check("R3", {1'b0, sym_valid}, {1'b0, exp_valid});
    check("R2", {1'b0, (sym_out == 2'b10)}, 2'b00);
  endtask

  initial begin
    rst = 1'b1; run = 1'b0; mode = 2'b00; sym_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", sym_out, 2'b00);
    check("R1", {1'b0, sym_valid}, 2'b00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1", sym_out, 2'b00);
    check("R1", {1'b0, sym_valid}, 2'b00);

    // Quiet mode with run high, then alternation with continuous and gapped enables
    for (int i = 0; i < 4; i++)  step(1'b1, 2'b00, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b1, 2'b01, 1'b1);
    for (int i = 0; i < 24; i++) step(1'b1, 2'b01, (i % 4) != 3);
    // Run mode: continuous, then sparse and three-of-four cadences across run edges
    for (int i = 0; i < 45; i++) step(1'b1, 2'b10, 1'b1);
    for (int i = 0; i < 70; i++) step(1'b1, 2'b10, (i % 3) == 0);
    for (int i = 0; i < 60; i++) step(1'b1, 2'b10, (i % 4) != 1);
    // Reserved mode acts as quiet
    for (int i = 0; i < 6; i++)  step(1'b1, 2'b11, 1'b1);
    // Mid-run switch to alternation, switch on an enabled cycle back to runs
    for (int i = 0; i < 13; i++) step(1'b1, 2'b10, 1'b1);
    for (int i = 0; i < 5; i++)  step(1'b1, 2'b01, 1'b1);
    for (int i = 0; i < 25; i++) step(1'b1, 2'b10, 1'b1);
    // Run dropped mid-pattern, then restored
    for (int i = 0; i < 3; i++)  step(1'b0, 2'b10, 1'b1);
    for (int i = 0; i < 25; i++) step(1'b1, 2'b10, (i % 2) == 0);
    for (int i = 0; i < 3; i++)  step(1'b1, 2'b01, 1'b1);
    step(1'b0, 2'b01, 1'b0);
    for (int i = 0; i < 6; i++)  step(1'b1, 2'b01, 1'b1);
    // Stall for many cycles inside a run
    for (int i = 0; i < 5; i++)  step(1'b1, 2'b10, 1'b0);
    for (int i = 0; i < 8; i++)  step(1'b1, 2'b10, i > 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule